// File: doc/BRIEF.md
# Programmable Delay Pre-Trigger Generator

This block schedules conversion start pulses for a multi-slot analog-to-digital converter. A software start pulse launches a counter that advances once per prescaled clock tick. The counter runs from zero up to a programmable end value. At programmable points inside each counting period the block issues single-cycle pre-trigger pulses, one output per converter slot. At one further programmable point it raises a sticky delay-match flag, which can drive an interrupt line.

Each pre-trigger channel can work in one of two ways. It can fire when the counter reaches its own delay value. In chained mode it instead fires one clock after the converter acknowledges the preceding channel, and channel 0 follows the last channel. This lets a set of conversions run back to back without the software having to size delay gaps against the conversion time.

The end value and all delay values are held in shadow registers. These are refreshed only by a load command, or on every clock when immediate loading is selected. Enables, output enables, chain selects, the prescaler choice and the run mode act directly. A sticky sequence-error flag records a trigger that was issued to a slot whose previous conversion had not yet been acknowledged.

Top module: `pretrig_timer`

## Requirements
- R1: While reset is held and right after it is released, all pre-trigger outputs, `busy`, `dly_flag`, `dly_irq` and `seq_err` are 0.
- R2: A one-cycle `sw_trig` captured at clock edge E0 starts a period with the counter at 0. The counter advances once every D = 2^`div_sel` clocks (encoding: `div_sel`=0 gives D=1, 1 gives 2, 2 gives 4, 3 gives 8), and `busy` is 1 from the clock after E0.
- R3: An unchained channel i with `chan_en[i]`=1 and `chan_oe[i]`=1, whose delay field `chan_dly[i*CNT_W +: CNT_W]` is d, drives `pretrig[i]` high for exactly one clock, namely the clock that follows edge E0 + (d+1)·D.
- R4: A channel fires at most once per counter period, and a channel with `chan_oe[i]`=0 never raises `pretrig[i]`.
- R5: A channel with `chan_en[i]`=0 never raises `pretrig[i]`.
- R6: With `chan_chain[i]`=1, channel i ignores its delay. It pulses one clock after `conv_ack` of channel i-1 is sampled high, and channel 0 takes its acknowledge from channel NCH-1.
- R7: When the counter reaches the end value M with `cont_mode`=1, a new period starts, so pulses repeat every (M+1)·D clocks. With `cont_mode`=0 the counter stops, `busy` drops after edge E0 + (M+1)·D, and no further pulses follow.
- R8: With `load_imm`=0, new values on `modulus`, `irq_dly` and `chan_dly` have no effect until a `load_cmd` pulse. With `load_imm`=1 they take effect from the next clock.
- R9: `dly_flag` becomes 1 in the clock after edge E0 + (k+1)·D, where k is the loaded `irq_dly`. It stays 1 until `flag_clr`, and `dly_irq` equals `dly_flag` AND `irq_en`.
- R10: `seq_err` becomes 1 when a channel issues a pulse while its previous pulse has not been acknowledged on `conv_ack[i]`. It stays 1 until `flag_clr`, and it stays 0 while every pulse is acknowledged before the same channel fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_trig | input | 1 | Start (or restart) a counting period |
| load_cmd | input | 1 | Copy end and delay inputs into the shadow registers |
| load_imm | input | 1 | Copy end and delay inputs into the shadow registers every clock |
| cont_mode | input | 1 | 1: restart at end value, 0: stop at end value |
| div_sel | input | SEL_W | Prescaler select, divide by 2^div_sel |
| modulus | input | CNT_W | Counter end value (buffered) |
| irq_dly | input | CNT_W | Delay-match point for the flag (buffered) |
| chan_dly | input | NCH*CNT_W | Per-channel delays, channel i at bits i*CNT_W upward (buffered) |
| chan_en | input | NCH | Channel enable |
| chan_oe | input | NCH | Channel output enable |
| chan_chain | input | NCH | Chain channel i to acknowledge of channel i-1 |
| conv_ack | input | NCH | Conversion-complete acknowledge per slot |
| irq_en | input | 1 | Interrupt enable for the delay-match flag |
| flag_clr | input | 1 | Clears dly_flag and seq_err |
| pretrig | output | NCH | Pre-trigger pulses |
| busy | output | 1 | Counter running |
| dly_flag | output | 1 | Sticky delay-match flag |
| dly_irq | output | 1 | Delay-match interrupt |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
Directed runs use spread delays at divide-by-1 and divide-by-4. Comparing the exact pulse clocks in these runs tells an off-by-one in the counter apart from a wrong prescale step. Masked-enable and masked-output runs separate the two gating bits. A continuous run that is switched to one-shot partway through checks the period length and the stop point. Two chained runs check the acknowledge-driven order, including the wrap from the last channel to the first. In both, the delays are deliberately set to clocks that would give an earlier pulse if the delay were not ignored. Randomised one-shot runs over prescale, end value, delays and masks are compared with pulse times computed by a bench function. Separate cases cover withholding the load command, immediate loading, and starving the acknowledge so that a slot is retriggered while still busy.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

  // Index of the channel whose acknowledge feeds a chained channel.
  function automatic int prev_chan(input int idx, input int nch);
    return (idx == 0) ? nch - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] pcnt_q, pcnt_d, limit;

  always_comb begin
    for (int b = 0; b < PW; b++) limit[b] = (b < int'(div_sel));
    tick = run && !restart && (pcnt_q == limit);
    if (restart || !run || tick) pcnt_d = '0;
    else                         pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             cont,
  input  logic [CNT_W-1:0] end_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             new_cycle
);
  import pdt_pkg::*;

  run_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    at_end = (st_q == ST_RUN) && tick && (cnt_q >= end_val);
    if (start) begin
      st_d  = ST_RUN;
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
      if (!cont) st_d = ST_IDLE;
    end else if ((st_q == ST_RUN) && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt       = cnt_q;
  assign running   = (st_q == ST_RUN);
  assign new_cycle = start | (at_end & cont);

endmodule

// File: rtl/pdt_chan.sv
module pdt_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             step,
  input  logic             new_cycle,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] dly,
  input  logic             ch_en,
  input  logic             out_en,
  input  logic             chain,
  input  logic             ack_prev,
  input  logic             ack_self,
  output logic             pulse,
  output logic             err
);
  logic fire, issue;
  logic fired_q, fired_d;
  logic busy_q, busy_d;
  logic pulse_q;

  always_comb begin
    fire    = armed & ch_en & ~fired_q &
              (chain ? ack_prev : (step & (cnt == dly)));
    issue   = fire & out_en;
    fired_d = new_cycle ? 1'b0 : (fired_q | fire);
    busy_d  = issue ? 1'b1 : (ack_self ? 1'b0 : busy_q);
    err     = issue & busy_q & ~ack_self;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      fired_q <= fired_d;
      busy_q  <= busy_d;
      pulse_q <= issue;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/pretrig_timer.sv
module pretrig_timer #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_trig,
  input  logic                 load_cmd,
  input  logic                 load_imm,
  input  logic                 cont_mode,
  input  logic [SEL_W-1:0]     div_sel,
  input  logic [CNT_W-1:0]     modulus,
  input  logic [CNT_W-1:0]     irq_dly,
  input  logic [NCH*CNT_W-1:0] chan_dly,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH-1:0]       chan_oe,
  input  logic [NCH-1:0]       chan_chain,
  input  logic [NCH-1:0]       conv_ack,
  input  logic                 irq_en,
  input  logic                 flag_clr,
  output logic [NCH-1:0]       pretrig,
  output logic                 busy,
  output logic                 dly_flag,
  output logic                 dly_irq,
  output logic                 seq_err
);
  localparam int DW = NCH * CNT_W;

  // Shadow copies of the buffered values
  logic [CNT_W-1:0] mod_sh, idly_sh;
  logic [DW-1:0]    cdly_sh;
  logic             load_now;

  assign load_now = load_cmd | load_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_sh  <= '0;
      idly_sh <= '0;
      cdly_sh <= '0;
    end else if (load_now) begin
      mod_sh  <= modulus;
      idly_sh <= irq_dly;
      cdly_sh <= chan_dly;
    end
  end

  // Time base
  logic             tick, running, new_cycle, armed;
  logic [CNT_W-1:0] cnt;

  pdt_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sw_trig),
    .run     (running),
    .div_sel (div_sel),
    .tick    (tick)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sw_trig),
    .tick      (tick),
    .cont      (cont_mode),
    .end_val   (mod_sh),
    .cnt       (cnt),
    .running   (running),
    .new_cycle (new_cycle)
  );

  assign armed = running & ~sw_trig;

  // Pre-trigger channels
  logic [NCH-1:0] err_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int PI = pdt_pkg::prev_chan(g, NCH);
    pdt_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .step      (tick),
      .new_cycle (new_cycle),
      .cnt       (cnt),
      .dly       (cdly_sh[g*CNT_W +: CNT_W]),
      .ch_en     (chan_en[g]),
      .out_en    (chan_oe[g]),
      .chain     (chan_chain[g]),
      .ack_prev  (conv_ack[PI]),
      .ack_self  (conv_ack[g]),
      .pulse     (pretrig[g]),
      .err       (err_vec[g])
    );
  end

  // Sticky flags
  logic flag_q, flag_d, serr_q, serr_d, dly_hit;

  always_comb begin
    dly_hit = tick & (cnt == idly_sh);
    flag_d  = dly_hit ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    serr_d  = (|err_vec) ? 1'b1 : (flag_clr ? 1'b0 : serr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      serr_q <= serr_d;
    end
  end

  assign busy     = running;
  assign dly_flag = flag_q;
  assign dly_irq  = flag_q & irq_en;
  assign seq_err  = serr_q;

endmodule

// File: rtl/pretrig_timer_chk.sv
module pretrig_timer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sw_trig,
  input logic           cont_mode,
  input logic           flag_clr,
  input logic [NCH-1:0] chan_chain,
  input logic [NCH-1:0] conv_ack,
  input logic [NCH-1:0] pretrig,
  input logic           busy,
  input logic           dly_flag,
  input logic           seq_err
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pretrig == '0 && !busy && !dly_flag && !seq_err)
        else $error("outputs active during reset");
    end
  end

  assert_start_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sw_trig));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (pretrig == '0));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(cont_mode));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_flag) && !$past(flag_clr)) |-> dly_flag);

  assert_serr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_err) && !$past(flag_clr)) |-> seq_err);

  for (genvar g = 0; g < NCH; g++) begin : g_chain
    localparam int PI = pdt_pkg::prev_chan(g, NCH);
    assert_chain_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pretrig[g] && $past(chan_chain[g])) |-> $past(conv_ack[PI]));
  end

endmodule

bind pretrig_timer pretrig_timer_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_trig    (sw_trig),
  .cont_mode  (cont_mode),
  .flag_clr   (flag_clr),
  .chan_chain (chan_chain),
  .conv_ack   (conv_ack),
  .pretrig    (pretrig),
  .busy       (busy),
  .dly_flag   (dly_flag),
  .seq_err    (seq_err)
);

// File: tb/pretrig_timer_bench.sv
module pretrig_timer_bench;
  localparam int CNT_W = 16;
  localparam int NCH   = 4;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic                 sw_trig, load_cmd, load_imm, cont_mode, irq_en, flag_clr;
  logic [SEL_W-1:0]     div_sel;
  logic [CNT_W-1:0]     modulus, irq_dly;
  logic [NCH*CNT_W-1:0] chan_dly;
  logic [NCH-1:0]       chan_en, chan_oe, chan_chain, conv_ack, ack_model, ack_force;
  logic [NCH-1:0]       pretrig;
  logic                 busy, dly_flag, dly_irq, seq_err;

  assign conv_ack = ack_model | ack_force;

  pretrig_timer #(.CNT_W(CNT_W), .NCH(NCH), .SEL_W(SEL_W)) u_pretrig_timer (
    .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .load_cmd(load_cmd),
    .load_imm(load_imm), .cont_mode(cont_mode), .div_sel(div_sel),
    .modulus(modulus), .irq_dly(irq_dly), .chan_dly(chan_dly),
    .chan_en(chan_en), .chan_oe(chan_oe), .chan_chain(chan_chain),
    .conv_ack(conv_ack), .irq_en(irq_en), .flag_clr(flag_clr),
    .pretrig(pretrig), .busy(busy), .dly_flag(dly_flag),
    .dly_irq(dly_irq), .seq_err(seq_err)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  int c0;
  int pcount[NCH], pfirst[NCH], plast[NCH], ctimer[NCH];
  int bfall, frise, conv_lat;
  bit busy_prev, flag_prev, auto_ack;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Monitor and converter model, both at the falling edge
  initial begin
    ack_model = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        ack_model[i] = 1'b0;
        if (ctimer[i] > 0) begin
          ctimer[i]--;
          if (ctimer[i] == 0 && auto_ack) ack_model[i] = 1'b1;
        end
        if (pretrig[i]) begin
          ctimer[i] = conv_lat;
          if (pcount[i] == 0) pfirst[i] = cyc;
          plast[i] = cyc;
          pcount[i]++;
        end
      end
      if (busy_prev && !busy) bfall = cyc;
      busy_prev = busy;
      if (!flag_prev && dly_flag) frise = cyc;
      flag_prev = dly_flag;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step1();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_at(input int base, input int d, input int sel);
    return base + (d + 1) * (1 << sel);
  endfunction

  task automatic set_dly(input int i, input int v);
    chan_dly[i*CNT_W +: CNT_W] = CNT_W'(v);
  endtask

  task automatic do_load();
    step1(); load_cmd = 1'b1;
    step1(); load_cmd = 1'b0;
  endtask

  task automatic start_run();
    step1();
    for (int i = 0; i < NCH; i++) begin
      pcount[i] = 0; pfirst[i] = -1; plast[i] = -1;
    end
    bfall = -1; frise = -1;
    sw_trig = 1'b1;
    step1();
    sw_trig = 1'b0;
    c0 = cyc;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) step1();
    repeat (12) step1();
  endtask

  task automatic check_oneshot(input string req, input int m, input int sel);
    for (int i = 0; i < NCH; i++) begin
      if (chan_en[i] && chan_oe[i] && !chan_chain[i]) begin
        chk(pcount[i] == 1, req, $sformatf("ch%0d pulse count", i), pcount[i], 1);
        chk(pfirst[i] == exp_at(c0, int'(chan_dly[i*CNT_W +: CNT_W]), sel), req,
            $sformatf("ch%0d pulse clock", i), pfirst[i],
            exp_at(c0, int'(chan_dly[i*CNT_W +: CNT_W]), sel));
      end else begin
        chk(pcount[i] == 0, req, $sformatf("ch%0d masked pulse count", i), pcount[i], 0);
      end
    end
    chk(bfall == exp_at(c0, m, sel), "R7", "one-shot stop clock", bfall, exp_at(c0, m, sel));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    sw_trig = 0; load_cmd = 0; load_imm = 0; cont_mode = 0; irq_en = 0; flag_clr = 0;
    div_sel = '0; modulus = '0; irq_dly = '0; chan_dly = '0;
    chan_en = '0; chan_oe = '0; chan_chain = '0; ack_force = '0;
    auto_ack = 1'b1; conv_lat = 2;
    for (int i = 0; i < NCH; i++) begin ctimer[i] = 0; pcount[i] = 0; end
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(pretrig == '0 && !busy, "R1", "outputs in reset", {busy, pretrig}, 0);
    rst_n = 1'b1;
    step1();
    chk(pretrig == '0, "R1", "pretrig after reset", pretrig, 0);
    chk(!busy && !dly_flag && !dly_irq && !seq_err, "R1", "status after reset",
        {busy, dly_flag, dly_irq, seq_err}, 0);

    // R2 R3: divide-by-1, spread delays, one-shot
    modulus = 20; set_dly(0, 0); set_dly(1, 5); set_dly(2, 12); set_dly(3, 20);
    chan_en = '1; chan_oe = '1; div_sel = 0;
    do_load();
    start_run();
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    wait_idle();
    check_oneshot("R3", 20, 0);
    chk(seq_err == 1'b0, "R10", "no error with timely acks", seq_err, 0);

    // R2 prescaler divide-by-4
    modulus = 10; set_dly(0, 1); set_dly(1, 3); set_dly(2, 7); set_dly(3, 10);
    div_sel = 2;
    do_load();
    start_run();
    wait_idle();
    check_oneshot("R2", 10, 2);

    // R4 R5: output-enable and enable masks
    chan_en = 4'b1101; chan_oe = 4'b1011; div_sel = 0;
    start_run();
    wait_idle();
    check_oneshot("R5", 10, 0);
    chk(pcount[2] == 0, "R4", "oe-masked channel silent", pcount[2], 0);
    chk(pcount[1] == 0, "R5", "disabled channel silent", pcount[1], 0);

    // R7 continuous, then switched to one-shot
    chan_en = '1; chan_oe = '1; div_sel = 1; modulus = 15;
    set_dly(0, 2); set_dly(1, 6); set_dly(2, 10); set_dly(3, 14);
    cont_mode = 1'b1;
    do_load();
    start_run();
    while (cyc < c0 + 2 * 32 + 5) step1();
    cont_mode = 1'b0;
    wait_idle();
    for (int i = 0; i < NCH; i++) begin
      chk(pcount[i] == 3, "R7", $sformatf("ch%0d repeats", i), pcount[i], 3);
      chk(plast[i] == exp_at(c0, 2 + 4 * i, 1) + 64, "R7",
          $sformatf("ch%0d third pulse clock", i), plast[i], exp_at(c0, 2 + 4 * i, 1) + 64);
    end
    chk(bfall == c0 + 96, "R7", "stop after third period", bfall, c0 + 96);

    // R8 buffered loading
    div_sel = 0; chan_en = 4'b0001; modulus = 20; set_dly(0, 3);
    do_load();
    modulus = 30; set_dly(0, 9);
    start_run();
    wait_idle();
    chk(pfirst[0] == c0 + 4, "R8", "old delay kept without load", pfirst[0], c0 + 4);
    chk(bfall == c0 + 21, "R8", "old end value kept", bfall, c0 + 21);
    do_load();
    start_run();
    wait_idle();
    chk(pfirst[0] == c0 + 10, "R8", "new delay after load", pfirst[0], c0 + 10);
    chk(bfall == c0 + 31, "R8", "new end value after load", bfall, c0 + 31);
    load_imm = 1'b1; set_dly(0, 6);
    step1();
    start_run();
    wait_idle();
    chk(pfirst[0] == c0 + 7, "R8", "immediate load", pfirst[0], c0 + 7);
    load_imm = 1'b0;

    // R9 delay-match flag and interrupt
    flag_clr = 1'b1; step1(); flag_clr = 1'b0;
    irq_dly = 8; irq_en = 1'b0;
    do_load();
    start_run();
    wait_idle();
    chk(frise == c0 + 9, "R9", "flag rise clock", frise, c0 + 9);
    chk(dly_flag == 1'b1 && dly_irq == 1'b0, "R9", "flag held, irq masked",
        {dly_flag, dly_irq}, 2);
    irq_en = 1'b1; step1();
    chk(dly_irq == 1'b1, "R9", "irq enabled", dly_irq, 1);
    flag_clr = 1'b1; step1(); flag_clr = 1'b0; step1();
    chk(dly_flag == 1'b0 && dly_irq == 1'b0, "R9", "flag cleared", {dly_flag, dly_irq}, 0);
    irq_en = 1'b0;

    // R6 chained sequence 0 -> 1 -> 2 -> 3
    conv_lat = 3; chan_en = '1; chan_oe = '1; chan_chain = 4'b1110; modulus = 200;
    set_dly(0, 4); set_dly(1, 1); set_dly(2, 1); set_dly(3, 1);
    do_load();
    start_run();
    wait_idle();
    chk(pfirst[0] == c0 + 5, "R6", "chain head clock", pfirst[0], c0 + 5);
    for (int i = 1; i < NCH; i++) begin
      chk(pfirst[i] == pfirst[i-1] + 4, "R6", $sformatf("ch%0d follows ack", i),
          pfirst[i], pfirst[i-1] + 4);
      chk(pcount[i] == 1, "R4", $sformatf("ch%0d once per period", i), pcount[i], 1);
    end

    // R6 wrap: 3 -> 0 -> 1, channel 2 on its own delay
    chan_chain = 4'b0011; modulus = 150;
    set_dly(0, 1); set_dly(1, 2); set_dly(2, 100); set_dly(3, 5);
    do_load();
    start_run();
    wait_idle();
    chk(pfirst[3] == c0 + 6, "R6", "wrap source clock", pfirst[3], c0 + 6);
    chk(pfirst[0] == pfirst[3] + 4, "R6", "ch0 follows last channel", pfirst[0], pfirst[3] + 4);
    chk(pfirst[1] == pfirst[0] + 4, "R6", "ch1 follows ch0", pfirst[1], pfirst[0] + 4);
    chk(pfirst[2] == c0 + 101 && pcount[0] == 1, "R6", "unchained ch2 on delay",
        pfirst[2], c0 + 101);
    chan_chain = '0; conv_lat = 1;

    // R10 sequence error with acknowledges withheld
    auto_ack = 1'b0; chan_en = 4'b0001; modulus = 5; set_dly(0, 1); cont_mode = 1'b1;
    do_load();
    start_run();
    repeat (3) step1();
    chk(seq_err == 1'b0, "R10", "no error after first pulse", seq_err, 0);
    repeat (10) step1();
    chk(seq_err == 1'b1, "R10", "error on retrigger of busy slot", seq_err, 1);
    cont_mode = 1'b0;
    wait_idle();
    flag_clr = 1'b1; ack_force = 4'b0001; step1();
    flag_clr = 1'b0; ack_force = '0; step1();
    chk(seq_err == 1'b0, "R10", "error cleared", seq_err, 0);
    auto_ack = 1'b1;

    // Random one-shot runs (R2 R3 R4 R5 R7)
    for (int r = 0; r < 6; r++) begin
      int sel, m;
      sel = int'($urandom_range(0, 2));
      m = int'($urandom_range(20, 60));
      div_sel = SEL_W'(sel);
      modulus = CNT_W'(m);
      for (int i = 0; i < NCH; i++) set_dly(i, int'($urandom_range(0, m)));
      chan_en = NCH'($urandom_range(0, 15));
      chan_oe = NCH'($urandom_range(0, 15));
      do_load();
      start_run();
      wait_idle();
      check_oneshot("R3", m, sel);
    end
    chk(seq_err == 1'b0, "R10", "no error over random runs", seq_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule